// File: doc/BRIEF.md
# Multichannel PWM Generator with Register Access

This block produces a set of independent pulse-width modulated outputs and is programmed over a simple 32-bit register bus. Each channel has two writable registers: one for the period length and one for the high time, both counted in cycles of the block clock. A constant read-only register reports the clock frequency in hertz. Software divides a wanted time by the clock period to get the counts it must write.

Each channel runs a counter from zero up to one less than its period and then wraps. The channel's output is high while the counter is below the high time, so every period opens with the high part of the pulse. New values are held in the writable registers until the running period ends, and only then do they reach the counter. A changed setting therefore never cuts a pulse short. A self-clearing bit in a control register returns the whole block to its reset state.

The bus uses byte addresses and a single write strobe. Reads are combinational from the address.

Top module: `pwm_bank`

## Requirements
- R1: Offset 0x20 reads the constant clock frequency parameter `BASE_HZ`. Writes to it have no effect.
- R2: The period register of channel n sits at byte offset 0x24 + 4·n. It can be written and read back as a full 32-bit value.
- R3: The high-time register of channel n sits at byte offset 0x24 + 4·NCH + 4·n. It can be written and read back as a full 32-bit value.
- R4: A channel with active period P > 0 and active high time H < P repeats a pattern of H cycles high followed by P − H cycles low. Its counter never reaches P.
- R5: An active high time at or above a non-zero active period keeps the output high all the time. An active period of 0 keeps the output low.
- R6: Values written to the period and high-time registers are copied into the active settings only at a period boundary, that is, the cycle after the counter holds P − 1, or on any cycle while the active period is 0. Between boundaries the active settings stay unchanged.
- R7: Writing a 1 to bit 0 of the control register (offset 0x00) sets a reset pulse one cycle later. While the pulse is set, bit 0 of offset 0x00 reads 1, every output is low, and bus writes are ignored. At the end of that one cycle, every register and counter is zero and the pulse is cleared.
- R8: Asynchronous active-low `rst_n` clears all registers, counters and outputs.
- R9: Reads of any offset that is not mapped return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting base of every channel |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | One pulse output per channel |

## Verification
Fixed cases come first, to separate the two constant-level cases: a high time above the period must hold the output high, while a zero period must hold it low even when the high time is non-zero. Next comes a stream of random writes, each setting a short period and high time. These writes land at random points inside running periods, so an early update shows as a cut pulse and a late one as a missed boundary. Random soft resets are mixed into the stream, and some writes fall inside the one-cycle reset pulse. This checks that those writes are dropped and that the channels restart cleanly.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter logic [31:0] BASE_HZ = 32'd100_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam logic [AW-1:0] CTRL_ADR = AW'(0);
  localparam logic [AW-1:0] FREQ_ADR = AW'(32'h20);
  localparam int PER0 = 32'h24;
  localparam int HI0  = 32'h24 + 4 * NCH;

  logic [31:0] per_reg [NCH];
  logic [31:0] hi_reg  [NCH];
  logic [31:0] per_act [NCH];
  logic [31:0] hi_act  [NCH];
  logic [31:0] cnt     [NCH];
  logic        srst_q;

  wire wr_ok = bus_wr && !srst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= wr_ok && bus_addr == CTRL_ADR && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        per_reg[n] <= '0;
        hi_reg[n]  <= '0;
      end
    end else if (srst_q) begin
      for (int n = 0; n < NCH; n++) begin
        per_reg[n] <= '0;
        hi_reg[n]  <= '0;
      end
    end else if (wr_ok) begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == AW'(PER0 + 4 * n)) per_reg[n] <= bus_wdata;
        if (bus_addr == AW'(HI0 + 4 * n))  hi_reg[n]  <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire wrap = per_act[g] == '0 || cnt[g] >= per_act[g] - 32'd1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0; per_act[g] <= '0; hi_act[g] <= '0;
      end else if (srst_q) begin
        cnt[g] <= '0; per_act[g] <= '0; hi_act[g] <= '0;
      end else if (wrap) begin
        cnt[g]     <= '0;
        per_act[g] <= per_reg[g];
        hi_act[g]  <= hi_reg[g];
      end else begin
        cnt[g] <= cnt[g] + 32'd1;
      end
    end

    assign pwm_out[g] = !srst_q && per_act[g] != '0 && cnt[g] < hi_act[g];

    // R4
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_act[g] != '0 |-> cnt[g] < per_act[g]);
    // R6
    hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_q && per_act[g] != '0 && cnt[g] != per_act[g] - 32'd1
        |=> $stable(per_act[g]) && $stable(hi_act[g]));
    // R7
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> per_reg[g] == '0 && hi_reg[g] == '0 && cnt[g] == '0);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FREQ_ADR) bus_rdata = BASE_HZ;
    if (bus_addr == CTRL_ADR) bus_rdata = {31'b0, srst_q};
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(PER0 + 4 * n)) bus_rdata = per_reg[n];
      if (bus_addr == AW'(HI0 + 4 * n))  bus_rdata = hi_reg[n];
    end
  end

  // R7
  srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  // R7
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> pwm_out == '0);
  // R1
  freq_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == FREQ_ADR |-> bus_rdata == BASE_HZ);
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int NCH = 4;
  localparam int AW = 8;
  localparam logic [31:0] HZ = 32'd100_000_000;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0, fails = 0;
  bit live = 0;

  always #5 clk = ~clk;

  pwm_bank #(.NCH(NCH), .AW(AW), .BASE_HZ(HZ)) uut (.*);

  int unsigned m_per[NCH], m_hi[NCH], m_pa[NCH], m_ha[NCH], m_cnt[NCH];
  bit m_rst;

  function automatic int per_adr(int n); return 32'h24 + 4 * n; endfunction
  function automatic int hi_adr(int n); return 32'h24 + 4 * NCH + 4 * n; endfunction
  function automatic bit exp_out(int n);
    return !m_rst && m_pa[n] != 0 && m_cnt[n] < m_ha[n];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 0;
      for (int n = 0; n < NCH; n++) begin
        m_per[n] = 0; m_hi[n] = 0; m_pa[n] = 0; m_ha[n] = 0; m_cnt[n] = 0;
      end
    end else if (m_rst) begin
      m_rst = 0;
      for (int n = 0; n < NCH; n++) begin
        m_per[n] = 0; m_hi[n] = 0; m_pa[n] = 0; m_ha[n] = 0; m_cnt[n] = 0;
      end
    end else begin
      for (int n = 0; n < NCH; n++)
        if (m_pa[n] == 0 || m_cnt[n] >= m_pa[n] - 1) begin
          m_cnt[n] = 0; m_pa[n] = m_per[n]; m_ha[n] = m_hi[n];
        end else m_cnt[n]++;
      if (bus_wr) begin
        for (int n = 0; n < NCH; n++) begin
          if (int'(bus_addr) == per_adr(n)) m_per[n] = bus_wdata;
          if (int'(bus_addr) == hi_adr(n))  m_hi[n]  = bus_wdata;
        end
        if (bus_addr == 0 && bus_wdata[0]) m_rst = 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    #2;
    for (int n = 0; n < NCH; n++)
      check("R4/R5/R6/R7 waveform", 32'(pwm_out[n]), 32'(exp_out(n)));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string req, int a, logic [31:0] exp);
    bus_addr = AW'(a); #1; check(req, bus_rdata, exp);
  endtask

  task automatic ticks(int k); repeat (k) @(negedge clk); endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd1234);
    ticks(3);
    rd("R8 reset out", 32'h00, 0);
    check("R8 reset pwm", 32'(pwm_out), 0);
    rst_n = 1;
    live = 1;
    ticks(2);
    rd("R1 freq", 32'h20, HZ);
    wr(32'h20, 32'h1234);
    rd("R1 freq after write", 32'h20, HZ);
    rd("R9 unmapped", 32'h24 + 8 * NCH, 0);
    rd("R9 unmapped 0x10", 32'h10, 0);
    for (int n = 0; n < NCH; n++) begin
      wr(per_adr(n), 32'hA5A5_0000 + n);
      wr(hi_adr(n), 32'h5A5A_0000 + n);
    end
    for (int n = 0; n < NCH; n++) begin
      rd("R2 period readback", per_adr(n), 32'hA5A5_0000 + n);
      rd("R3 high readback", hi_adr(n), 32'h5A5A_0000 + n);
    end
    wr(32'h00, 1);
    rd("R7 pulse visible", 32'h00, 1);
    check("R7 outputs low", 32'(pwm_out), 0);
    @(negedge clk);
    rd("R7 pulse cleared", 32'h00, 0);
    rd("R7 period cleared", per_adr(0), 0);
    // R5 constant high and constant low
    wr(per_adr(1), 5); wr(hi_adr(1), 9);
    wr(hi_adr(2), 3);
    ticks(3);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      check("R5 high>=period stays high", 32'(pwm_out[1]), 1);
      check("R5 zero period stays low", 32'(pwm_out[2]), 0);
    end
    // R4 pattern count: period 7, high 3
    wr(per_adr(0), 7); wr(hi_adr(0), 3);
    ticks(10);
    begin
      int hi_cnt = 0;
      for (int k = 0; k < 70; k++) begin
        @(negedge clk); #1;
        if (pwm_out[0]) hi_cnt++;
      end
      check("R4 high cycles in 10 periods", hi_cnt, 30);
    end
    // R6 mid-period change; the per-cycle model check covers the exact timing
    wr(per_adr(0), 4); wr(hi_adr(0), 4);
    ticks(20);
    // R7 write inside the reset pulse is dropped
    wr(32'h00, 1);
    @(negedge clk);
    wr(per_adr(3), 9);
    rd("R7 write after pulse kept", per_adr(3), 9);
    @(negedge clk); bus_addr = AW'(32'h00); bus_wdata = 1; bus_wr = 1;
    @(negedge clk); bus_addr = AW'(per_adr(3)); bus_wdata = 77;
    @(negedge clk); bus_wr = 0;
    rd("R7 write during pulse ignored", per_adr(3), 0);
    for (int i = 0; i < 1500; i++) begin
      r = $urandom_range(99);
      if (r < 3) wr(32'h00, 1);
      else if (r < 40) begin
        int n = $urandom_range(NCH - 1);
        if (r & 1) wr(per_adr(n), $urandom_range(12));
        else       wr(hi_adr(n), $urandom_range(14));
      end else ticks($urandom_range(6));
    end
    live = 0;
    ticks(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule